// File: doc/BRIEF.md
# Boot-Configurable Flash Address Remapper

This block sits between a CPU's 24-bit address bus and the memory selects. For every address it decides whether the access goes to the 256 KB on-chip flash or to external memory. When the access goes to flash, it also produces the byte offset into the flash array. The decision is combinational. It depends on three configuration bits held in a small register: a flash enable, a low-block placement bit and a segmentation-disable bit. The flash enable is loaded at hardware reset from a boot pin, so a board can start either from on-chip flash or from external boot memory.

The flash is split into two parts. The first 32 KB is a relocatable low block. A single bit places it either at the bottom of segment 0 or at the bottom of segment 1. The remaining 224 KB always sits at 01_8000h–04_FFFFh. Boot code may rewrite the configuration until it issues an end-of-init strobe, and writes after that strobe are ignored.

Any accepted write that changes the map raises a pending flag. The flag stays up until the CPU reports an inter-segment jump. This tells software that its next fetch must come through a long jump and that its data page pointers must be reloaded.

Top module: `flash_remap`

## Requirements
- R1: While reset is held, the flash enable takes the level of `bootFlashPin`, the placement bit is 1, the segmentation-disable bit is 1 and `remapPending` is 0.
- R2: With the flash enable at 0, every address gives `extSel`=1 and `flashSel`=0.
- R3: With the enable at 1 and the placement bit at 1, addresses 00_0000h–00_7FFFh select flash with offset equal to the address. Addresses 01_0000h–01_7FFFh then go external.
- R4: With the enable at 1, the placement bit at 0 and segmentation enabled, addresses 01_0000h–01_7FFFh select flash with offset address−01_0000h. Addresses 00_0000h–00_7FFFh then go external.
- R5: With the enable at 1 and segmentation enabled, addresses 01_8000h–04_FFFFh select flash with offset address−01_0000h, whatever the placement bit holds.
- R6: While the segmentation-disable bit is 1, no address at or above 01_0000h selects flash.
- R7: Addresses outside every active window (including 00_8000h–00_FFFFh and 05_0000h upward) select external memory, and exactly one of `flashSel` and `extSel` is high at all times.
- R8: A write through `cfgWe` loads `cfgWdata` (bit 0 enable, bit 1 placement, bit 2 segmentation-disable) at the next clock edge. A write in the same cycle as `endInit` is still accepted. Every write in a later cycle is ignored, until the next reset.
- R9: An accepted write that changes any of the three bits sets `remapPending` at the next edge. An accepted write that changes nothing leaves the flag as it was.
- R10: `segJump` clears `remapPending` at the next edge. If a map-changing write falls in the same cycle, the flag stays set.
- R11: After the cycle of `endInit`, `remapPending` can no longer rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bootFlashPin | input | 1 | Boot level copied into the flash enable during reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 3 | New configuration: bit 2 segmentation-disable, bit 1 placement, bit 0 enable |
| endInit | input | 1 | End-of-initialisation strobe; locks the configuration |
| segJump | input | 1 | Pulse reporting that an inter-segment jump executed |
| cpuAddr | input | 24 | CPU byte address |
| flashSel | output | 1 | Access targets on-chip flash |
| extSel | output | 1 | Access targets external memory |
| flashOffset | output | 18 | Byte offset into flash, valid while flashSel is high |
| remapPending | output | 1 | Map changed; a long jump and pointer reload are still owed |

## Verification
A map-changing configuration write and an inter-segment jump can land in the same cycle. Directed steps drive both together, and the random phase issues writes and jumps at independent rates so that they collide often. The bench judges the result by requiring `remapPending` to remain high in the following cycle. A second collision, a write in the cycle of `endInit`, is provoked directly. The write must then show up in the address decode afterwards, while writes one cycle later must leave both the decode and the flag untouched.

// File: rtl/flash_remap_pkg.sv
package flash_remap_pkg;

  // Layout matches the write data bus: bit 2 segDis, bit 1 lowAtZero, bit 0 enable
  typedef struct packed {
    logic segDis;
    logic lowAtZero;
    logic enable;
  } mapCfg_t;

  localparam int CFG_W = $bits(mapCfg_t);

endpackage

// File: rtl/fmr_ctrl.sv
module fmr_ctrl
  import flash_remap_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootFlashPin,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             endInit,
  input  logic             segJump,
  output mapCfg_t          cfg,
  output logic             remapPending
);

  mapCfg_t cfgQ;
  mapCfg_t wrCfg;
  logic    lockQ;
  logic    pendQ;
  logic    accept;
  logic    mapChange;

  assign wrCfg     = mapCfg_t'(cfgWdata);
  assign accept    = cfgWe && !lockQ;
  assign mapChange = accept && (wrCfg != cfgQ);

  // Configuration register; enable follows the boot pin while in reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ.enable    <= bootFlashPin;
      cfgQ.lowAtZero <= 1'b1;
      cfgQ.segDis    <= 1'b1;
    end else if (accept) begin
      cfgQ <= wrCfg;
    end
  end

  // Sticky lock after end of init
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (endInit) lockQ <= 1'b1;
  end

  // Pending flag: a new change outranks a concurrent jump
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendQ <= 1'b0;
    else if (mapChange) pendQ <= 1'b1;
    else if (segJump)   pendQ <= 1'b0;
  end

  assign cfg          = cfgQ;
  assign remapPending = pendQ;

  // R8: once locked, the configuration holds
  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockQ) |-> (cfgQ == $past(cfgQ)));

  // R8: the lock never drops without reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockQ) |-> lockQ);

  // R11: no new pending after lock
  p_no_late_pend_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lockQ) && !$past(pendQ)) |-> !pendQ);

  // R10: a jump without a concurrent change clears the flag
  p_jump_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(segJump && !(cfgWe && !lockQ && cfgWdata != cfgQ)) |-> !pendQ);

  // R9: an unlocked write that differs raises the flag
  p_change_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWe && !lockQ && cfgWdata != cfgQ) |-> pendQ);

endmodule

// File: rtl/fmr_decode.sv
module fmr_decode
  import flash_remap_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int FLASH_BYTES = 32'h40000,
  parameter int LOW_BYTES   = 32'h8000,
  parameter int SEG_BYTES   = 32'h10000,
  parameter int UPPER_BASE  = 32'h18000,
  parameter int OFF_W       = $clog2(FLASH_BYTES)
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  mapCfg_t           cfg,
  output logic              flashSel,
  output logic              extSel,
  output logic [OFF_W-1:0]  flashOffset
);

  localparam int NUM_WIN    = 3;
  localparam int UPPER_LAST = UPPER_BASE + FLASH_BYTES - LOW_BYTES - 1;

  logic [NUM_WIN-1:0] allow;
  logic [NUM_WIN-1:0] hit;
  logic [OFF_W-1:0]   offArr [NUM_WIN];

  // Window 0: low block in segment 0; 1: low block in segment 1; 2: fixed upper
  always_comb begin
    allow[0] = cfg.enable &&  cfg.lowAtZero;
    allow[1] = cfg.enable && !cfg.lowAtZero && !cfg.segDis;
    allow[2] = cfg.enable && !cfg.segDis;
  end

  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    localparam int WBASE = (gi == 0) ? 0 : (gi == 1) ? SEG_BYTES : UPPER_BASE;
    localparam int WLAST = (gi == 0) ? LOW_BYTES - 1 :
                           (gi == 1) ? SEG_BYTES + LOW_BYTES - 1 : UPPER_LAST;
    localparam int WOFF  = (gi == 2) ? LOW_BYTES : 0;
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WBASE);
    localparam logic [ADDR_W-1:0] LAST_V = ADDR_W'(WLAST);
    localparam logic [ADDR_W-1:0] OFF_V  = ADDR_W'(WOFF);

    logic geBase;
    if (WBASE == 0) begin : g_zero
      assign geBase = 1'b1;
    end else begin : g_cmp
      assign geBase = (cpuAddr >= BASE_V);
    end

    assign hit[gi]    = allow[gi] && geBase && (cpuAddr <= LAST_V);
    assign offArr[gi] = OFF_W'(cpuAddr - BASE_V + OFF_V);
  end

  // Windows are disjoint, so an OR-merge picks the single hit
  always_comb begin
    flashOffset = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (hit[i]) flashOffset = flashOffset | offArr[i];
    end
    flashSel = |hit;
    extSel   = ~flashSel;
  end

endmodule

// File: rtl/flash_remap.sv
module flash_remap
  import flash_remap_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int FLASH_BYTES = 32'h40000,
  parameter int LOW_BYTES   = 32'h8000,
  parameter int SEG_BYTES   = 32'h10000,
  parameter int UPPER_BASE  = 32'h18000,
  parameter int OFF_W       = $clog2(FLASH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bootFlashPin,
  input  logic              cfgWe,
  input  logic [2:0]        cfgWdata,
  input  logic              endInit,
  input  logic              segJump,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              flashSel,
  output logic              extSel,
  output logic [OFF_W-1:0]  flashOffset,
  output logic              remapPending
);

  mapCfg_t cfg;

  fmr_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .bootFlashPin (bootFlashPin),
    .cfgWe        (cfgWe),
    .cfgWdata     (cfgWdata),
    .endInit      (endInit),
    .segJump      (segJump),
    .cfg          (cfg),
    .remapPending (remapPending)
  );

  fmr_decode #(
    .ADDR_W      (ADDR_W),
    .FLASH_BYTES (FLASH_BYTES),
    .LOW_BYTES   (LOW_BYTES),
    .SEG_BYTES   (SEG_BYTES),
    .UPPER_BASE  (UPPER_BASE),
    .OFF_W       (OFF_W)
  ) u_decode (
    .cpuAddr     (cpuAddr),
    .cfg         (cfg),
    .flashSel    (flashSel),
    .extSel      (extSel),
    .flashOffset (flashOffset)
  );

  // R7: exactly one target
  p_one_select_r7: assert property (@(posedge clk) disable iff (!rstN)
    flashSel != extSel);

  // R2: disabled flash routes everything outside
  p_disabled_ext_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |-> (extSel && !flashSel));

  // R6: segmentation disabled confines flash to segment 0
  p_segdis_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.segDis && flashSel) |-> (cpuAddr < ADDR_W'(SEG_BYTES)));

endmodule

// File: tb/flash_remap_tb.sv
module flash_remap_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int OFF_W      = 18;

  logic              clk = 1'b0;
  logic              rstN;
  logic              bootFlashPin;
  logic              cfgWe;
  logic [2:0]        cfgWdata;
  logic              endInit;
  logic              segJump;
  logic [ADDR_W-1:0] cpuAddr;
  logic              flashSel;
  logic              extSel;
  logic [OFF_W-1:0]  flashOffset;
  logic              remapPending;

  int vecCnt = 0;
  int errCnt = 0;

  // Reference state
  logic mEn, mLow, mSeg, mLock, mPend;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_remap u_dut (
    .clk(clk), .rstN(rstN), .bootFlashPin(bootFlashPin), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .endInit(endInit), .segJump(segJump),
    .cpuAddr(cpuAddr), .flashSel(flashSel), .extSel(extSel),
    .flashOffset(flashOffset), .remapPending(remapPending)
  );

  // Returns {select, offset}
  function automatic logic [OFF_W:0] expDecode(logic [ADDR_W-1:0] a);
    if (!mEn) return '0;
    if (mLow && a < 24'h008000) return {1'b1, OFF_W'(a)};
    if (!mLow && !mSeg && a >= 24'h010000 && a <= 24'h017FFF)
      return {1'b1, OFF_W'(a - 24'h010000)};
    if (!mSeg && a >= 24'h018000 && a <= 24'h04FFFF)
      return {1'b1, OFF_W'(a - 24'h010000)};
    return '0;
  endfunction

  function automatic string reqTag(logic [ADDR_W-1:0] a);
    if (!mEn) return "R2";
    if (mSeg && a >= 24'h010000) return "R6";
    if (a < 24'h008000) return mLow ? "R3" : "R4";
    if (a >= 24'h010000 && a <= 24'h017FFF) return mLow ? "R3" : "R4";
    if (a >= 24'h018000 && a <= 24'h04FFFF) return "R5";
    return "R7";
  endfunction

  task automatic checkNow(string pendTag);
    logic [OFF_W:0] e;
    e = expDecode(cpuAddr);
    vecCnt++;
    if (flashSel !== e[OFF_W] || extSel !== !e[OFF_W] ||
        (e[OFF_W] && flashOffset !== e[OFF_W-1:0])) begin
      errCnt++;
      $display("FAIL %s addr=%06h act sel=%b/%b off=%05h exp sel=%b off=%05h",
               reqTag(cpuAddr), cpuAddr, flashSel, extSel, flashOffset,
               e[OFF_W], e[OFF_W-1:0]);
    end
    vecCnt++;
    if (remapPending !== mPend) begin
      errCnt++;
      $display("FAIL %s pending act=%b exp=%b", pendTag, remapPending, mPend);
    end
  endtask

  // Apply one cycle of stimulus; outputs are checked before the edge
  task automatic step(logic we, logic [2:0] wd, logic ei, logic jmp,
                      logic [ADDR_W-1:0] a, string pendTag);
    logic acc, chg;
    @(negedge clk);
    cfgWe = we; cfgWdata = wd; endInit = ei; segJump = jmp; cpuAddr = a;
    #1;
    checkNow(pendTag);
    @(posedge clk);
    acc = we && !mLock;
    chg = acc && (wd != {mSeg, mLow, mEn});
    if (acc) {mSeg, mLow, mEn} = wd;
    if (chg) mPend = 1'b1;
    else if (jmp) mPend = 1'b0;
    if (ei) mLock = 1'b1;
  endtask

  task automatic doReset(logic pin);
    @(negedge clk);
    rstN = 1'b0; bootFlashPin = pin;
    cfgWe = 0; cfgWdata = 0; endInit = 0; segJump = 0; cpuAddr = 24'h000100;
    mEn = pin; mLow = 1'b1; mSeg = 1'b1; mLock = 1'b0; mPend = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    checkNow("R1");             // R1: reset state seen during reset
    rstN = 1'b1;
  endtask

  function automatic logic [ADDR_W-1:0] pickAddr();
    logic [ADDR_W-1:0] edges [8] = '{24'h007FFF, 24'h008000, 24'h00FFFF,
      24'h010000, 24'h017FFF, 24'h018000, 24'h04FFFF, 24'h050000};
    int k = int'($urandom_range(0, 3));
    if (k == 0) return edges[$urandom_range(0, 7)];
    if (k == 1) return ADDR_W'($urandom);
    return ADDR_W'($urandom_range(0, 32'h5FFFF));
  endfunction

  task automatic randomPhase(int n, logic allowEnd);
    for (int i = 0; i < n; i++) begin
      logic we  = ($urandom_range(0, 7) == 0);
      logic jmp = ($urandom_range(0, 3) == 0);
      logic ei  = allowEnd && ($urandom_range(0, 99) == 0);
      step(we, 3'($urandom), ei, jmp, pickAddr(), mLock ? "R11" : "R9");
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errCnt++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0;
    doReset(1'b0);

    // R2: disabled flash
    step(0, 0, 0, 0, 24'h000000, "R1");
    step(0, 0, 0, 0, 24'h020000, "R1");
    // R9: enable with low block at zero
    step(1, 3'b111, 0, 0, 24'h000000, "R9");
    step(0, 0, 0, 0, 24'h007FFF, "R9");   // R3
    step(0, 0, 0, 0, 24'h018000, "R9");   // R6
    // R10: jump clears
    step(0, 0, 0, 1, 24'h010000, "R10");
    // R4 / R5 layout
    step(1, 3'b001, 0, 0, 24'h010000, "R10");
    step(0, 0, 0, 0, 24'h010000, "R9");
    step(0, 0, 0, 0, 24'h017FFF, "R9");
    step(0, 0, 0, 0, 24'h000000, "R9");
    step(0, 0, 0, 0, 24'h018000, "R9");
    step(0, 0, 0, 0, 24'h04FFFF, "R9");
    step(0, 0, 0, 0, 24'h050000, "R9");   // R7
    step(0, 0, 0, 0, 24'h008000, "R9");   // R7
    // R9: unchanged write plus jump -> clears
    step(1, 3'b001, 0, 1, 24'h000000, "R9");
    // R10: changing write and jump together -> stays set
    step(1, 3'b011, 0, 1, 24'h000000, "R10");
    step(0, 0, 0, 0, 24'h018000, "R10");
    step(0, 0, 0, 1, 24'h000000, "R10");

    randomPhase(3000, 1'b0);

    // R8: write in the endInit cycle is accepted
    step(1, 3'b001, 1, 0, 24'h010000, "R8");
    step(0, 0, 0, 1, 24'h010000, "R8");
    // R8 / R11: later writes ignored
    step(1, 3'b110, 0, 0, 24'h010000, "R11");
    step(0, 0, 0, 0, 24'h010000, "R11");
    step(0, 0, 0, 0, 24'h020000, "R11");
    randomPhase(1500, 1'b0);

    doReset(1'b1);
    step(0, 0, 0, 0, 24'h004000, "R1");
    randomPhase(4000, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule